// File: doc/BRIEF.md
# Sixteen-Line Serial Receiver with Shared Tagged Queue

This block receives asynchronous serial characters on a set of input lines (sixteen by default) and merges them into one queue. It does not give each line its own receiver. A single assembly engine visits the lines in turn, one line per clock. Each line keeps its own framing phase, oversample count, bit index and partial character in a small state array, and that state persists from one visit to the next. A full scan of all lines counts as one oversample tick per line. One bit time is therefore `NLINES*OVS` clocks, which is 256 clocks at the defaults. Every character is checked at its stop bit, and every completed character is written into a shared circular queue of `DEPTH` entries (64 by default). Each queue entry carries the line number, the character and a framing-error flag.

Framing is global. A two-bit length code selects five to eight data bits, and the data bits arrive least significant bit first after a low start bit. A line held at space through a whole character, including the stop position, is reported as a break on that line and produces no queue entry. A receive interrupt goes high whenever the queue holds data and the interrupt is enabled.

Software drains the queue through a valid/ready read port. An entry stays on the port, unchanged, for as long as `rd_ready` stays low. The entry is consumed on the clock edge where `rd_valid` and `rd_ready` are both high. The receive side cannot be stalled. A character that arrives while the queue is full is lost, and a sticky overrun flag records the loss.

Top module: `mlrx_top`

## Requirements
- R1: Reset empties the queue and drives `rd_valid`, `irq`, `ovr_flag` and every bit of `brk_flags` low.
- R2: A frame on line n is a low start bit, the data bits least significant first and a high stop bit. It yields one entry with `rd_line`=n and the data right-justified in `rd_char` with zero upper bits. Every bit is sampled near its middle at 16 samples per bit, and one bit lasts `NLINES*OVS` clocks.
- R3: All lines receive concurrently and independently, and entries leave the queue in the order their frames completed.
- R4: The length code `char_len` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3.
- R5: A frame whose stop bit samples low while at least one data bit was high yields an entry with `rd_ferr`=1. Good frames carry `rd_ferr`=0.
- R6: A low pulse on a line that has ended before the middle of the start bit yields no entry.
- R7: When the start, data and stop positions all sample low, `brk_flags[n]` is set and no entry is written. The flag clears once line n returns high.
- R8: A character completing while all `DEPTH` entries are occupied (counted at the start of that cycle) is discarded. It sets `ovr_flag`, which stays high until `ovr_clr` is pulsed.
- R9: While `rd_valid` is high and `rd_ready` is low, the port holds its entry unchanged. The entry is removed on a cycle where both are high.
- R10: `irq` is high exactly when `rd_valid` and `irq_en` are both high.
- R11: The queue holds `DEPTH` entries, and on overrun the first `DEPTH` characters are kept in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | NLINES | Serial inputs, idle high |
| char_len | input | 2 | Data length code (5 + code bits) |
| irq_en | input | 1 | Receive interrupt enable |
| ovr_clr | input | 1 | Pulse to clear the overrun flag |
| rd_valid | output | 1 | Queue head entry is present |
| rd_ready | input | 1 | Consumer accepts the head entry |
| rd_line | output | $clog2(NLINES) | Line number of the head entry |
| rd_char | output | 8 | Character of the head entry |
| rd_ferr | output | 1 | Framing error of the head entry |
| brk_flags | output | NLINES | Per-line break status |
| ovr_flag | output | 1 | Sticky overrun flag |
| irq | output | 1 | Receive interrupt |

## Verification
The bench goes after several corner cases, each of which would show up as a wrong or extra queue entry or a wrong flag:
- **Break versus framing error.** A design that confused the two would queue a null character during a break, or would drop a real character whose stop bit was bad.
- **False start.** A glitch shorter than half a bit is sent on its own, and a bad stop bit leaves the line low just long enough to look like a new start bit. An engine that skipped the mid-bit confirmation would emit phantom characters.
- **Merged lines.** Staggered bursts on all sixteen lines test two things. State mixed up between lines would give wrong tags or wrong data. An engine that lost track of its position would give a wrong order.
- **Full queue.** Filling the queue past its capacity and then draining it under back-pressure checks that the oldest entries survive. A design that overwrote the oldest entry, or let the head change during a stall, would fail here.

// File: rtl/mlrx_pkg.sv
`timescale 1ns/100ps
package mlrx_pkg;

  // Per-line framing phase held in the shared state array
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_STOP  = 3'd3,
    PH_BREAK = 3'd4
  } phase_e;

  localparam int unsigned CHAR_W = 8;

endpackage

// File: rtl/mlrx_sync.sv
`timescale 1ns/100ps
module mlrx_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  // Two-stage synchronizer per line; reset to mark (idle high)
  for (genvar g = 0; g < W; g++) begin : g_line
    logic [1:0] stg_q;
    always_ff @(posedge clk) begin
      if (!rst_n) stg_q <= 2'b11;
      else        stg_q <= {stg_q[0], async_i[g]};
    end
    assign sync_o[g] = stg_q[1];
  end

endmodule

// File: rtl/mlrx_engine.sv
`timescale 1ns/100ps
module mlrx_engine
  import mlrx_pkg::*;
#(
  parameter int unsigned NLINES = 16,
  parameter int unsigned OVS    = 16,
  parameter int unsigned LW     = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] rx_i,
  input  logic [1:0]        char_len_i,
  output logic              push_o,
  output logic [LW-1:0]     line_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              ferr_o,
  output logic [NLINES-1:0] brk_o
);

  localparam int unsigned CW   = $clog2(OVS);
  localparam int unsigned HALF = OVS / 2;

  // Shared per-line state, visited one line per clock
  phase_e            ph_q  [NLINES];
  logic [CW-1:0]     cnt_q [NLINES];
  logic [2:0]        bit_q [NLINES];
  logic [CHAR_W-1:0] sh_q  [NLINES];
  logic [NLINES-1:0] brk_q;
  logic [LW-1:0]     idx_q;

  phase_e            ph_n;
  logic [CW-1:0]     cnt_n;
  logic [2:0]        bit_n;
  logic [CHAR_W-1:0] sh_n;
  logic              smp;
  logic              brk_set, brk_clr;
  logic [2:0]        last_bit;
  logic [1:0]        shamt;

  assign last_bit = 3'd4 + {1'b0, char_len_i};
  assign shamt    = 2'd3 - char_len_i;
  assign smp      = rx_i[idx_q];

  always_comb begin
    ph_n    = ph_q[idx_q];
    cnt_n   = cnt_q[idx_q];
    bit_n   = bit_q[idx_q];
    sh_n    = sh_q[idx_q];
    brk_set = 1'b0;
    brk_clr = 1'b0;
    push_o  = 1'b0;
    ferr_o  = 1'b0;
    unique case (ph_n)
      PH_IDLE: begin
        if (!smp) begin
          ph_n  = PH_START;
          cnt_n = '0;
        end
      end
      PH_START: begin
        if (cnt_n == CW'(HALF - 1)) begin
          if (!smp) begin
            ph_n  = PH_DATA;
            cnt_n = '0;
            bit_n = '0;
            sh_n  = '0;
          end else begin
            ph_n = PH_IDLE;
          end
        end else begin
          cnt_n = cnt_n + 1'b1;
        end
      end
      PH_DATA: begin
        if (cnt_n == CW'(OVS - 1)) begin
          cnt_n = '0;
          sh_n  = {smp, sh_n[CHAR_W-1:1]};
          if (bit_n == last_bit) ph_n = PH_STOP;
          else                   bit_n = bit_n + 1'b1;
        end else begin
          cnt_n = cnt_n + 1'b1;
        end
      end
      PH_STOP: begin
        if (cnt_n == CW'(OVS - 1)) begin
          if (smp) begin
            push_o = 1'b1;
            ph_n   = PH_IDLE;
          end else if (sh_n == '0) begin
            brk_set = 1'b1;
            ph_n    = PH_BREAK;
          end else begin
            push_o = 1'b1;
            ferr_o = 1'b1;
            ph_n   = PH_IDLE;
          end
        end else begin
          cnt_n = cnt_n + 1'b1;
        end
      end
      PH_BREAK: begin
        if (smp) begin
          brk_clr = 1'b1;
          ph_n    = PH_IDLE;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  assign line_o = idx_q;
  assign char_o = sh_n >> shamt;
  assign brk_o  = brk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      brk_q <= '0;
      for (int i = 0; i < NLINES; i++) begin
        ph_q[i]  <= PH_IDLE;
        cnt_q[i] <= '0;
        bit_q[i] <= '0;
        sh_q[i]  <= '0;
      end
    end else begin
      ph_q[idx_q]  <= ph_n;
      cnt_q[idx_q] <= cnt_n;
      bit_q[idx_q] <= bit_n;
      sh_q[idx_q]  <= sh_n;
      if (brk_set) brk_q[idx_q] <= 1'b1;
      if (brk_clr) brk_q[idx_q] <= 1'b0;
      idx_q <= (idx_q == LW'(NLINES - 1)) ? '0 : idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/mlrx_fifo.sv
`timescale 1ns/100ps
module mlrx_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 13,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data,
  input  logic         ovr_clr,
  output logic         ovr_flag,
  output logic [AW:0]  occ
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt_q;
  logic          full, do_wr, do_rd, ovr_q;

  assign full     = (cnt_q == (AW+1)'(DEPTH));
  assign do_wr    = wr_en && !full;
  assign rd_valid = (cnt_q != '0);
  assign do_rd    = rd_valid && rd_ready;
  assign rd_data  = mem[rd_ptr];
  assign ovr_flag = ovr_q;
  assign occ      = cnt_q;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (wr_en && full) ovr_q <= 1'b1;
      else if (ovr_clr)  ovr_q <= 1'b0;
    end
  end

endmodule

// File: rtl/mlrx_top.sv
`timescale 1ns/100ps
module mlrx_top
  import mlrx_pkg::*;
#(
  parameter int unsigned NLINES = 16,
  parameter int unsigned OVS    = 16,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned LW     = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] rx_line,
  input  logic [1:0]        char_len,
  input  logic              irq_en,
  input  logic              ovr_clr,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [LW-1:0]     rd_line,
  output logic [CHAR_W-1:0] rd_char,
  output logic              rd_ferr,
  output logic [NLINES-1:0] brk_flags,
  output logic              ovr_flag,
  output logic              irq
);

  localparam int unsigned EW = LW + CHAR_W + 1;
  localparam int unsigned AW = $clog2(DEPTH);

  logic [NLINES-1:0] rx_s;
  logic              push;
  logic [LW-1:0]     push_line;
  logic [CHAR_W-1:0] push_char;
  logic              push_ferr;
  logic [EW-1:0]     head;
  logic [AW:0]       fifo_occ;

  mlrx_sync #(.W(NLINES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(rx_line),
    .sync_o (rx_s)
  );

  mlrx_engine #(.NLINES(NLINES), .OVS(OVS), .LW(LW)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_i      (rx_s),
    .char_len_i(char_len),
    .push_o    (push),
    .line_o    (push_line),
    .char_o    (push_char),
    .ferr_o    (push_ferr),
    .brk_o     (brk_flags)
  );

  mlrx_fifo #(.DEPTH(DEPTH), .W(EW), .AW(AW)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push),
    .wr_data ({push_line, push_char, push_ferr}),
    .rd_valid(rd_valid),
    .rd_ready(rd_ready),
    .rd_data (head),
    .ovr_clr (ovr_clr),
    .ovr_flag(ovr_flag),
    .occ     (fifo_occ)
  );

  assign {rd_line, rd_char, rd_ferr} = head;
  assign irq = irq_en && rd_valid;

endmodule

// File: rtl/mlrx_chk.sv
`timescale 1ns/100ps
module mlrx_chk #(
  parameter int unsigned LW    = 4,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [LW-1:0] rd_line,
  input logic [7:0]    rd_char,
  input logic          rd_ferr,
  input logic          irq,
  input logic          irq_en,
  input logic          ovr_flag,
  input logic          ovr_clr,
  input logic [AW:0]   occ
);

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_line) && $stable(rd_char) && $stable(rd_ferr)); // R9

  AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_valid && irq_en); // R10

  AST_IRQ_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && irq_en |-> irq); // R10

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag && !ovr_clr |=> ovr_flag); // R8

  AST_OVR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(occ) == (AW+1)'(DEPTH)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (AW+1)'(DEPTH)); // R11

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> occ <= $past(occ) + 1'b1); // R11

endmodule

bind mlrx_top mlrx_chk #(.LW(LW), .DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_valid(rd_valid),
  .rd_ready(rd_ready),
  .rd_line (rd_line),
  .rd_char (rd_char),
  .rd_ferr (rd_ferr),
  .irq     (irq),
  .irq_en  (irq_en),
  .ovr_flag(ovr_flag),
  .ovr_clr (ovr_clr),
  .occ     (fifo_occ)
);

// File: tb/test_mlrx_top.sv
`timescale 1ns/100ps
module test_mlrx_top;

  localparam int NL    = 16;
  localparam int OVS   = 16;
  localparam int DEPTH = 64;
  localparam int LW    = 4;
  localparam int BIT   = NL * OVS;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] rx;
  logic [1:0]    char_len;
  logic          irq_en, ovr_clr, rd_ready;
  logic          rd_valid, rd_ferr, ovr_flag, irq;
  logic [LW-1:0] rd_line;
  logic [7:0]    rd_char;
  logic [NL-1:0] brk_flags;

  always #2.5 clk = ~clk;

  mlrx_top #(.NLINES(NL), .OVS(OVS), .DEPTH(DEPTH)) i_mlrx_top (
    .clk(clk), .rst_n(rst_n), .rx_line(rx), .char_len(char_len),
    .irq_en(irq_en), .ovr_clr(ovr_clr), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_line(rd_line), .rd_char(rd_char),
    .rd_ferr(rd_ferr), .brk_flags(brk_flags), .ovr_flag(ovr_flag), .irq(irq)
  );

  // Reference model: queue of expected entries {line, char, ferr}
  logic [12:0] mq[$];
  bit          ovr_m;
  bit          drain;
  int          n_cmp, n_bad, cyc, n_popped;

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Drives one frame on a line; the model entry is recorded at frame start
  task automatic send(input int ln, input logic [7:0] d, input int nb,
                      input bit stop_ok, input int lead);
    logic [7:0] m;
    m = d & 8'((9'h1 << nb) - 1);
    repeat (lead) @(negedge clk);
    if (!(stop_ok == 1'b0 && m == 8'h00)) begin
      if (mq.size() < DEPTH) mq.push_back({4'(ln), m, ~stop_ok});
      else                   ovr_m = 1'b1;
    end
    rx[ln] = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      rx[ln] = m[b];
      repeat (BIT) @(negedge clk);
    end
    if (stop_ok) begin
      rx[ln] = 1'b1;
      repeat (BIT) @(negedge clk);
    end else begin
      rx[ln] = 1'b0;
      repeat (BIT * 5 / 8) @(negedge clk);
      rx[ln] = 1'b1;
      repeat (BIT) @(negedge clk);
    end
  endtask

  // All lines, starts staggered so completion order follows line order
  task automatic burst(input int nb, input int seed);
    for (int l = 0; l < NL; l++) begin
      automatic int ll = l;
      fork
        send(ll, 8'((ll * 37 + seed * 11 + 5) & 255), nb, 1'b1, 1 + ll * 40);
      join_none
    end
    wait fork;
  endtask

  task automatic settle(input string req);
    repeat (600) @(negedge clk);
    chk(!rd_valid, req, "queue drained", int'(rd_valid), 0);
    chk(mq.size() == 0, req, "model drained", mq.size(), 0);
  endtask

  // Every-clock comparison, read handshake and watchdog
  initial begin
    rd_ready = 1'b0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 190000) begin
        chk(1'b0, "R1", "watchdog expired", cyc, 0);
        summary_and_end();
      end
      if (rd_valid) begin
        // R9 no entry without a recorded frame; R2 head matches model
        chk(mq.size() != 0, "R9", "spurious entry", {rd_line, rd_char, rd_ferr}, 0);
        if (mq.size() != 0)
          chk({rd_line, rd_char, rd_ferr} == mq[0], "R2", "head entry",
              {rd_line, rd_char, rd_ferr}, mq[0]);
      end
      chk(irq == (rd_valid && irq_en), "R10", "irq level", irq, rd_valid && irq_en);
      rd_ready = drain && (cyc % 3 != 1);
      if (rd_valid && rd_ready && mq.size() != 0) begin
        void'(mq.pop_front());
        n_popped++;
      end
    end
  end

  initial begin
    rst_n = 1'b0; rx = '1; char_len = 2'd3; irq_en = 1'b1; ovr_clr = 1'b0;
    drain = 1'b1; ovr_m = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!rd_valid, "R1", "rd_valid after reset", rd_valid, 0);
    chk(!irq, "R1", "irq after reset", irq, 0);
    chk(!ovr_flag, "R1", "ovr after reset", ovr_flag, 0);
    chk(brk_flags == '0, "R1", "brk after reset", brk_flags, 0);

    // R2 R3 eight-bit burst on every line, drained with back-pressure
    burst(8, 1);
    settle("R3");

    // R4 other lengths
    char_len = 2'd0; burst(5, 2); settle("R4");
    char_len = 2'd2; burst(7, 3); settle("R4");
    char_len = 2'd3;

    // R5 bad stop bit on line 3 beside a good frame on line 9
    fork
      send(3, 8'hA5, 8, 1'b0, 1);
      send(9, 8'h3C, 8, 1'b1, 40);
    join
    settle("R5");

    // R6 short glitch on line 5
    rx[5] = 1'b0; repeat (60) @(negedge clk); rx[5] = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    chk(!rd_valid, "R6", "no entry after glitch", rd_valid, 0);

    // R7 break on lines 2 and 12
    rx[2] = 1'b0; rx[12] = 1'b0;
    repeat (11 * BIT) @(negedge clk);
    chk(brk_flags == 16'h1004, "R7", "break flags set", brk_flags, 16'h1004);
    chk(!rd_valid, "R7", "no entry during break", rd_valid, 0);
    rx[2] = 1'b1;
    repeat (100) @(negedge clk);
    chk(brk_flags == 16'h1000, "R7", "line 2 break cleared", brk_flags, 16'h1000);
    rx[12] = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    chk(brk_flags == '0, "R7", "all breaks cleared", brk_flags, 0);
    chk(!rd_valid, "R7", "no entry after break", rd_valid, 0);

    // R10 interrupt gated by enable
    drain = 1'b0; irq_en = 1'b0;
    send(7, 8'h5A, 8, 1'b1, 1);
    repeat (50) @(negedge clk);
    chk(rd_valid && !irq, "R10", "irq masked", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq, "R10", "irq enabled", irq, 1);
    drain = 1'b1;
    settle("R10");

    // R8 R11 overrun: five bursts with no draining
    drain = 1'b0;
    for (int k = 0; k < 5; k++) burst(8, 10 + k);
    repeat (200) @(negedge clk);
    chk(ovr_flag == ovr_m, "R8", "overrun flag set", ovr_flag, ovr_m);
    chk(mq.size() == DEPTH, "R11", "model holds capacity", mq.size(), DEPTH);
    n_popped = 0;
    drain = 1'b1;
    repeat (400) @(negedge clk);
    chk(n_popped == DEPTH, "R11", "entries retained", n_popped, DEPTH);
    chk(!rd_valid, "R11", "queue empty after drain", rd_valid, 0);
    chk(ovr_flag, "R8", "overrun sticky", ovr_flag, 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    @(negedge clk);
    chk(!ovr_flag, "R8", "overrun cleared", ovr_flag, 0);

    summary_and_end();
  end

endmodule